// File: doc/BRIEF.md
# Passive Serial FPGA Configurator

This block loads a configuration image into an FPGA over the passive serial interface. On a start request it holds the device's configuration-reset pin low for a fixed time, then releases it. It waits a fixed ready interval, because there is no status pin to report when the device is ready. It then takes image bytes from a valid/ready stream and shifts them out one bit at a time on a data pin, with a clock it derives from the system clock.

Progress is judged only from the device's configuration-done input. That input is sampled at the end of every byte. Once it is seen high, the block issues a fixed number of extra clock periods so the device can start up, and then raises `done_o`. If the stream ends, or the byte limit is reached, while configuration-done is still low, the block raises `error_o` and stops the clock. Both delays are counted in system clocks, computed from the `CLK_HZ` parameter.

Top module: `ps_fpga_configurator`

## Requirements
- R1: While bits or startup clocks are being sent, `dclk_o` has a period of 2*HALF_CYC system clocks. With the default HALF_CYC=2 it is high for exactly 2 cycles and low for at least 2 cycles.
- R2: A start request taken in the idle, done or error state drives `nconfig_o` low for exactly LOW_CYC = ceil(CLK_HZ*NCFG_LOW_NS/1e9) cycles. During that time `dclk_o` and `byte_ready_o` stay low.
- R3: After `nconfig_o` returns high, no rising edge of `dclk_o` occurs for at least WAIT_CYC = ceil(CLK_HZ*READY_WAIT_NS/1e9) cycles.
- R4: Each byte is sent least significant bit first, one bit per rising edge of `dclk_o`. `data0_o` changes only while `dclk_o` is low and is stable at every rising edge.
- R5: `byte_ready_o` is high only while the block waits for the next byte, and `dclk_o` stays low throughout that wait, however long the input is stalled.
- R6: If `conf_done_i` is high when a byte has been fully sent, no further bytes are taken. Exactly STARTUP_CLKS more rising edges of `dclk_o` follow, and then `done_o` goes high.
- R7: If the byte marked with `byte_last_i` finishes while `conf_done_i` is low, `error_o` goes high. After that `dclk_o` has no more rising edges and no more bytes are taken.
- R8: If MAX_BYTES bytes have been sent and `conf_done_i` is low at the end of the last one, `error_o` goes high and no further byte is accepted. If `conf_done_i` is high at that point, R6 applies instead.
- R9: While `rst_n` is low, and right after it, `nconfig_o`=1, `dclk_o`=0, `byte_ready_o`=0, `done_o`=0 and `error_o`=0, even if reset arrives in the middle of a load.
- R10: `done_o` and `error_o` are never high together. Each holds until the next start request, and a start request from either state begins a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a configuration load |
| byte_data_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Image byte is present |
| byte_last_i | input | 1 | Marks the final byte of the image |
| byte_ready_o | output | 1 | Block takes a byte this cycle if valid |
| conf_done_i | input | 1 | Configuration-done from the device |
| nconfig_o | output | 1 | Active-low configuration reset to the device |
| dclk_o | output | 1 | Configuration clock to the device |
| data0_o | output | 1 | Serial configuration data to the device |
| done_o | output | 1 | Load and startup clocks finished |
| error_o | output | 1 | Image ran out before configuration-done |

## Verification
The assertions assume that `conf_done_i` does not fall during a load once it has risen. This holds because the device asserts it only after it has its full image. They also assume the byte stream only offers data while it is being loaded. The stimulus models the device: it clears `conf_done_i` at each start and raises it only at the negative clock edge right after the final data bit of the chosen byte is sampled. All inputs change at negative clock edges, so every handshake is settled before the next active edge.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NCFG_LOW,
    ST_READY_WAIT,
    ST_LOAD,
    ST_SHIFT,
    ST_STARTUP,
    ST_DONE,
    ST_ERROR
  } ps_state_e;

  // Converts a duration in nanoseconds to system clocks, rounded up, never zero.
  function automatic longint unsigned ns_to_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned ns);
    longint unsigned c;
    c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ps_delay_timer.sv
module ps_delay_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  // Loaded with N, expired_o is high in the N-th cycle after the load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       run_i,
  output logic       dclk_o,
  output logic       data_o,
  output logic       period_end_o,
  output logic       last_bit_o
);

  localparam int PERIOD = 2 * HALF_CYC;
  localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(HALF_CYC);

  logic [PW-1:0] phase_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else if (load_i) begin
      phase_q <= '0;
      bit_q   <= '0;
      sh_q    <= byte_i;
    end else if (run_i) begin
      if (phase_q == PH_LAST) begin
        phase_q <= '0;
        bit_q   <= bit_q + 1'b1;
        sh_q    <= {1'b0, sh_q[7:1]};
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  // Low half first: the data bit is set up before the rising edge.
  assign dclk_o       = run_i && (phase_q >= PH_HIGH);
  assign data_o       = sh_q[0];
  assign period_end_o = run_i && (phase_q == PH_LAST);
  assign last_bit_o   = (bit_q == 3'd7);

endmodule

// File: rtl/ps_fpga_configurator.sv
module ps_fpga_configurator #(
  parameter int CLK_HZ        = 80_000_000,
  parameter int NCFG_LOW_NS   = 2_000,
  parameter int READY_WAIT_NS = 200_000,
  parameter int STARTUP_CLKS  = 100,
  parameter int MAX_BYTES     = 524_288,
  parameter int HALF_CYC      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] byte_data_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  input  logic       conf_done_i,
  output logic       nconfig_o,
  output logic       dclk_o,
  output logic       data0_o,
  output logic       done_o,
  output logic       error_o
);
  import ps_cfg_pkg::*;

  localparam int LOW_CYC  = int'(ns_to_cycles(64'(CLK_HZ), 64'(NCFG_LOW_NS)));
  localparam int WAIT_CYC = int'(ns_to_cycles(64'(CLK_HZ), 64'(READY_WAIT_NS)));
  localparam int TW       = $clog2(max_int(LOW_CYC, WAIT_CYC) + 1);
  localparam int BCW      = $clog2(MAX_BYTES + 1);
  localparam int SUW      = $clog2(STARTUP_CLKS + 1);

  ps_state_e      state_q, state_d;
  logic           last_q;
  logic [BCW-1:0] byte_cnt_q;
  logic [SUW-1:0] su_cnt_q;

  // Named internal events, also used by the checker.
  logic start_ok_w, accept_w, run_w, byte_end_w, startup_end_w;
  logic tmr_load_w, tmr_expired_w, period_end_w, last_bit_w;
  logic [TW-1:0] tmr_val_w;

  assign start_ok_w    = start_i && (state_q == ST_IDLE || state_q == ST_DONE ||
                                     state_q == ST_ERROR);
  assign byte_ready_o  = (state_q == ST_LOAD);
  assign accept_w      = byte_ready_o && byte_valid_i;
  assign run_w         = (state_q == ST_SHIFT) || (state_q == ST_STARTUP);
  assign byte_end_w    = (state_q == ST_SHIFT) && period_end_w && last_bit_w;
  assign startup_end_w = (state_q == ST_STARTUP) && period_end_w &&
                         (su_cnt_q == SUW'(STARTUP_CLKS - 1));
  assign tmr_load_w    = start_ok_w || (state_q == ST_NCFG_LOW && tmr_expired_w);
  assign tmr_val_w     = (state_q == ST_NCFG_LOW) ? TW'(WAIT_CYC) : TW'(LOW_CYC);

  ps_delay_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load_w),
    .load_val_i (tmr_val_w),
    .expired_o  (tmr_expired_w)
  );

  ps_bit_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (accept_w),
    .byte_i       (byte_data_i),
    .run_i        (run_w),
    .dclk_o       (dclk_o),
    .data_o       (data0_o),
    .period_end_o (period_end_w),
    .last_bit_o   (last_bit_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_ERROR: if (start_ok_w) state_d = ST_NCFG_LOW;
      ST_NCFG_LOW:   if (tmr_expired_w) state_d = ST_READY_WAIT;
      ST_READY_WAIT: if (tmr_expired_w) state_d = ST_LOAD;
      ST_LOAD:       if (accept_w) state_d = ST_SHIFT;
      ST_SHIFT: begin
        if (byte_end_w) begin
          if (conf_done_i)                                 state_d = ST_STARTUP;
          else if (last_q || byte_cnt_q == BCW'(MAX_BYTES)) state_d = ST_ERROR;
          else                                             state_d = ST_LOAD;
        end
      end
      ST_STARTUP:    if (startup_end_w) state_d = ST_DONE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      last_q     <= 1'b0;
      byte_cnt_q <= '0;
      su_cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok_w) begin
        byte_cnt_q <= '0;
        last_q     <= 1'b0;
      end else if (accept_w) begin
        byte_cnt_q <= byte_cnt_q + 1'b1;
        last_q     <= byte_last_i;
      end
      if (byte_end_w)                               su_cnt_q <= '0;
      else if (state_q == ST_STARTUP && period_end_w) su_cnt_q <= su_cnt_q + 1'b1;
    end
  end

  assign nconfig_o = (state_q != ST_NCFG_LOW);
  assign done_o    = (state_q == ST_DONE);
  assign error_o   = (state_q == ST_ERROR);

endmodule

// File: rtl/ps_cfg_checker.sv
module ps_cfg_checker #(
  parameter int WAIT_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic nconfig_o,
  input logic dclk_o,
  input logic data0_o,
  input logic byte_ready_o,
  input logic conf_done_i,
  input logic done_o,
  input logic error_o,
  input logic byte_end_w
);

  logic [31:0] since_rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      since_rel_q <= '0;
    else if (!nconfig_o)             since_rel_q <= '0;
    else if (since_rel_q != '1)      since_rel_q <= since_rel_q + 1'b1;
  end

  AST_DCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |=> dclk_o ##1 !dclk_o);                           // R1
  AST_DCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk_o) |=> !dclk_o);                                      // R1
  AST_NCFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !nconfig_o |-> (!dclk_o && !byte_ready_o));                      // R2
  AST_READY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> (since_rel_q >= 32'(WAIT_CYC)));               // R3
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> $stable(data0_o));                             // R4
  AST_WAIT_DCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> !dclk_o);                                       // R5
  AST_DONE_AFTER_CD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> conf_done_i);                                  // R6
  AST_CD_NO_MORE_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end_w && conf_done_i) |=> (!byte_ready_o && !error_o));    // R6
  AST_END_NO_CD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end_w && !conf_done_i) |=> (byte_ready_o || error_o));     // R7
  AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (!dclk_o && !byte_ready_o && nconfig_o));            // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));                                           // R10

endmodule

bind ps_fpga_configurator ps_cfg_checker #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .nconfig_o    (nconfig_o),
  .dclk_o       (dclk_o),
  .data0_o      (data0_o),
  .byte_ready_o (byte_ready_o),
  .conf_done_i  (conf_done_i),
  .done_o       (done_o),
  .error_o      (error_o),
  .byte_end_w   (byte_end_w)
);

// File: tb/ps_fpga_configurator_bench.sv
module ps_fpga_configurator_bench;

  localparam int CLK_HZ   = 20_000_000;
  localparam int MAXB     = 6;
  localparam int SU_CLKS  = 100;
  // Own arithmetic: cycles per microsecond times microseconds.
  localparam int EXP_LOW  = (CLK_HZ / 1_000_000) * 2;
  localparam int EXP_WAIT = (CLK_HZ / 1_000_000) * 200;
  localparam int NVEC     = 7;
  // Fields: image length, byte after which conf_done rises (0 = never),
  // stall cycles between bytes, last-flag used.
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd4, 4'd4, 4'd0, 4'd1},
    {4'd3, 4'd1, 4'd0, 4'd1},
    {4'd5, 4'd3, 4'd3, 4'd1},
    {4'd2, 4'd0, 4'd0, 4'd1},
    {4'd9, 4'd0, 4'd0, 4'd0},
    {4'd6, 4'd6, 4'd2, 4'd0},
    {4'd1, 4'd1, 4'd0, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] byte_data_i = '0;
  logic byte_valid_i = 1'b0;
  logic byte_last_i = 1'b0;
  logic conf_done_i = 1'b0;
  logic byte_ready_o, nconfig_o, dclk_o, data0_o, done_o, error_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ps_fpga_configurator #(
    .CLK_HZ(CLK_HZ), .STARTUP_CLKS(SU_CLKS), .MAX_BYTES(MAXB)
  ) u_ps_fpga_configurator (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_data_i(byte_data_i),
    .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
    .byte_ready_o(byte_ready_o), .conf_done_i(conf_done_i),
    .nconfig_o(nconfig_o), .dclk_o(dclk_o), .data0_o(data0_o),
    .done_o(done_o), .error_o(error_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'((v * 29 + i * 83 + 8'h3C) ^ 8'h5A);
  endfunction

  task automatic run_case(input int v, input int len, input int cd, input int gap,
                          input bit use_last);
    int limit, exp_bytes, idx, gap_left, low_cnt, low_width, rel_cnt, first_gap;
    int bitk, rx_count, bad_data, bad_space, su_rises, ovl, post_rises, post_ready;
    int cyc, last_rise, post;
    bit pend, released, cd_set, exp_done, fin, got_rise, timeout;
    logic prev_dclk, prev_ncfg;
    logic [7:0] rx;
    limit = use_last ? ((len < MAXB) ? len : MAXB) : MAXB;
    exp_done = (cd != 0) && (cd <= limit);
    exp_bytes = exp_done ? cd : limit;
    idx = 0; gap_left = 0; low_cnt = 0; low_width = -1; rel_cnt = 0; first_gap = -1;
    bitk = 0; rx_count = 0; bad_data = 0; bad_space = 0; su_rises = 0; ovl = 0;
    post_rises = 0; post_ready = 0; cyc = 0; last_rise = 0; post = 0;
    pend = 0; released = 0; cd_set = 0; fin = 0; got_rise = 0; timeout = 0;
    rx = '0; prev_dclk = 1'b0; prev_ncfg = 1'b1;
    @(negedge clk);
    conf_done_i = 1'b0; byte_valid_i = 1'b0; byte_last_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (post < 20) begin
      // Stream source: advance after a handshake, stall, then offer next byte.
      if (pend) begin
        idx++; byte_valid_i = 1'b0; gap_left = gap;
      end
      if (!byte_valid_i && !(use_last && idx >= len)) begin
        if (gap_left > 0) gap_left--;
        else begin
          byte_valid_i = 1'b1; byte_data_i = pat(v, idx);
          byte_last_i = use_last && (idx == len - 1);
        end
      end
      pend = byte_ready_o && byte_valid_i;
      // Device model and observation.
      if (!nconfig_o) low_cnt++;
      if (released && !got_rise) rel_cnt++;
      if (!prev_ncfg && nconfig_o) begin
        low_width = low_cnt; released = 1; rel_cnt = 0;
      end
      if (byte_ready_o && dclk_o) ovl++;
      if (dclk_o && !prev_dclk) begin
        if (!got_rise) first_gap = rel_cnt;
        got_rise = 1;
        if (fin) post_rises++;
        else if (cd_set) su_rises++;
        else begin
          if (bitk != 0 && cyc - last_rise != 4) bad_space++;
          rx = {data0_o, rx[7:1]};
          bitk++;
          if (bitk == 8) begin
            if (rx != pat(v, rx_count)) bad_data++;
            rx_count++; bitk = 0;
            if (rx_count == cd) begin cd_set = 1; conf_done_i = 1'b1; end
          end
        end
        last_rise = cyc;
      end
      if (fin) begin
        post++;
        if (byte_ready_o) post_ready++;
      end
      if (done_o || error_o) fin = 1;
      prev_dclk = dclk_o; prev_ncfg = nconfig_o;
      cyc++;
      if (cyc > 12000) begin timeout = 1; break; end
      @(negedge clk);
    end
    check("R2", $sformatf("case%0d not stuck", v), int'(timeout), 0);
    check("R2", $sformatf("case%0d nconfig low width", v), low_width, EXP_LOW);
    check("R3", $sformatf("case%0d wait before first dclk ok", v),
          int'(first_gap >= EXP_WAIT), 1);
    check("R1", $sformatf("case%0d bit spacing errors", v), bad_space, 0);
    check("R4", $sformatf("case%0d byte mismatches", v), bad_data, 0);
    check("R5", $sformatf("case%0d dclk high while waiting", v), ovl, 0);
    check("R8", $sformatf("case%0d bytes sent", v), rx_count, exp_bytes);
    check("R6", $sformatf("case%0d done flag", v), int'(done_o), int'(exp_done));
    check("R7", $sformatf("case%0d error flag", v), int'(error_o), int'(!exp_done));
    check("R6", $sformatf("case%0d startup rises", v), su_rises, exp_done ? SU_CLKS : 0);
    check("R7", $sformatf("case%0d rises after finish", v), post_rises, 0);
    check("R10", $sformatf("case%0d ready after finish", v), post_ready, 0);
    byte_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "nconfig in reset", int'(nconfig_o), 1);
    check("R9", "dclk in reset", int'(dclk_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "ready after reset", int'(byte_ready_o), 0);
    check("R9", "done/error after reset", int'(done_o | error_o), 0);
    check("R9", "nconfig after reset", int'(nconfig_o), 1);

    for (int v = 0; v < NVEC; v++) begin
      run_case(v, int'(VEC[v][15:12]), int'(VEC[v][11:8]), int'(VEC[v][7:4]),
               VEC[v][0]);
    end

    // R10: flags held with no start request.
    repeat (50) @(negedge clk);
    check("R10", "done held without start", int'(done_o), 1);
    check("R10", "error low while done", int'(error_o), 0);

    // R9: reset in the middle of shifting.
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    byte_valid_i = 1'b1; byte_data_i = 8'hFF; byte_last_i = 1'b0;
    for (int i = 0; i < EXP_LOW + EXP_WAIT + 20; i++) @(negedge clk);
    check("R9", "mid-load activity started", int'(byte_ready_o == 1'b0 && nconfig_o), 1);
    rst_n = 1'b0;
    #1;
    check("R9", "dclk forced low by reset", int'(dclk_o), 0);
    check("R9", "ready low in reset", int'(byte_ready_o), 0);
    check("R9", "flags low in reset", int'(done_o | error_o), 0);
    byte_valid_i = 1'b0;
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check("R9", "nconfig high after mid reset", int'(nconfig_o), 1);
    check("R9", "idle after mid reset", int'(dclk_o | byte_ready_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190_000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule